// File: doc/BRIEF.md
# IPv4 Output Port Lookup Stage

This stage sits in a router datapath between the ingress arbiter and the output queues. For each packet it receives the Ethernet addresses, the 20-byte IPv4 header and the index of the queue the packet came from. It returns a rewritten header, a forwarding verdict and a module header word that names the output queue. All of this appears one clock cycle after the input strobe.

Queue indices interleave the two kinds of port. MAC port k has index 2k, and the CPU queue paired with it has index 2k+1.

A packet from a MAC port goes through these checks:
- its destination MAC must equal the MAC address of its ingress port;
- its header checksum must be valid;
- its TTL must be above 1;
- its destination address must match a route;
- the route's next hop must have an ARP entry.

When every check passes, the packet is forwarded. Its destination MAC becomes the next-hop MAC and its source MAC becomes the egress port's MAC. Its TTL is decremented and its checksum is updated incrementally. Any failed check diverts the packet, unmodified, to the CPU queue paired with its ingress port. A packet injected by a CPU queue 2k+1 skips every check and leaves on MAC index 2k unchanged.

Three small tables are loaded through one write port: the route table (prefix, mask, next hop, egress MAC port), the ARP table (IP to 48-bit MAC) and the per-port MAC addresses.

Top module: `olkLookup`

## Requirements
- R1: Each cycle with inValid high produces outValid high exactly one cycle later, and a cycle without inValid produces outValid low one cycle later. After reset outValid is low.
- R2: Whenever outValid is high, outModCtrl is 0x04 and outModHdr equals the zero-extended outPortIdx. Whenever outValid is low, outModCtrl is 0.
- R3: A packet with an odd inSrcPort (2k+1, a CPU queue) is not checked. It leaves on index 2k with outExcept low, and its MACs and IPv4 header are unchanged.
- R4: A packet from MAC port k (inSrcPort = 2k) with TTL 0 or 1 has outExcept high and outPortIdx 2k+1. Its MACs and header are unchanged. TTL is bits [95:88] of inIpHdr, where 16-bit header word w occupies bits [159-16w -: 16].
- R5: A packet from MAC port k whose inDstMac differs from the MAC address loaded for port k is sent to index 2k+1 unchanged.
- R6: A packet from a MAC port whose header checksum is bad is sent to its paired CPU index unchanged. A checksum is bad when the ones'-complement sum of the ten header words is not 0xFFFF.
- R7: Route lookup matches (dstIp & mask) == prefix, where dstIp is bits [31:0]. The matching entry with the most mask bits wins. A packet that matches no route goes to the CPU index.
- R8: The winning route's next-hop IP is looked up in the ARP table. A miss sends the packet to the CPU index. A hit sets outDstMac to the ARP entry's MAC.
- R9: A forwarded packet leaves on index 2p, where p is the route's egress port, with outExcept low. outSrcMac is the MAC of port p. The TTL is one less, the checksum makes the ten words sum to 0xFFFF again, and every other header bit is unchanged.
- R10: wrEn writes one entry: wrSel 0 writes a route, 1 writes an ARP entry, 2 writes a port MAC. A write takes effect for packets from the next cycle on, not for a packet presented in the same cycle. Reset empties the route and ARP tables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Table write strobe |
| wrSel | input | 2 | Table select: 0 route, 1 ARP, 2 port MAC |
| wrIdx | input | TW | Entry index within the selected table |
| wrKey | input | 32 | Route prefix or ARP IP address |
| wrMask | input | 32 | Route mask |
| wrNextHop | input | 32 | Route next-hop IP |
| wrMac | input | 48 | ARP MAC or port MAC |
| wrPort | input | MW | Route egress MAC port number |
| inValid | input | 1 | Packet header present |
| inSrcPort | input | IW | Ingress queue index (even MAC, odd CPU) |
| inDstMac | input | 48 | Ethernet destination address |
| inSrcMac | input | 48 | Ethernet source address |
| inIpHdr | input | 160 | IPv4 header, word 0 in the top bits |
| outValid | output | 1 | Result present |
| outModCtrl | output | 8 | Control value of the prepended module header |
| outModHdr | output | 64 | Module header data word carrying the output index |
| outPortIdx | output | IW | Output queue index |
| outExcept | output | 1 | Packet diverted to a CPU queue |
| outDstMac | output | 48 | Outgoing destination MAC |
| outSrcMac | output | 48 | Outgoing source MAC |
| outIpHdr | output | 160 | Outgoing IPv4 header |

## Verification
A table write and a packet lookup can share a clock edge. The question is then whether the packet sees the old or the new table contents. The bench provokes this by presenting, in the same cycle as a write, a packet whose ARP entry is exactly the one being written. It expects a CPU diversion for that packet and a normal forward for an identical packet one cycle later. Several failures can also coincide in one packet, such as a low TTL together with a bad checksum and a route miss. Random traffic mixes these combinations, and each result is judged against a bench model that only needs to agree on a single diversion to the paired CPU index.

// File: rtl/olkPkg.sv
package olkPkg;
  localparam logic [7:0] MOD_CTRL = 8'h04;
  localparam logic [1:0] SEL_ROUTE = 2'd0;
  localparam logic [1:0] SEL_ARP   = 2'd1;
  localparam logic [1:0] SEL_PMAC  = 2'd2;

  typedef struct packed {
    logic load;     // capture a result this cycle
    logic fwd;      // rewrite and send to looked-up MAC port
    logic toCpu;    // divert unmodified to paired CPU queue
    logic fromCpu;  // CPU-injected packet, pass to paired MAC
  } olkStrobeT;
endpackage

// File: rtl/olkCtrl.sv
module olkCtrl
  import olkPkg::*;
(
  input  logic      inValid,
  input  logic      isCpuSrc,
  input  logic      macOk,
  input  logic      csumOk,
  input  logic      ttlOk,
  input  logic      routeHit,
  input  logic      arpHit,
  output olkStrobeT strobe
);
  logic allOk;

  always_comb begin
    allOk          = macOk && csumOk && ttlOk && routeHit && arpHit;
    strobe.load    = inValid;
    strobe.fromCpu = inValid && isCpuSrc;
    strobe.fwd     = inValid && !isCpuSrc && allOk;
    strobe.toCpu   = inValid && !isCpuSrc && !allOk;
  end
endmodule

// File: rtl/olkData.sv
module olkData
  import olkPkg::*;
#(
  parameter int NUM_MAC = 4,
  parameter int NUM_LPM = 4,
  parameter int NUM_ARP = 4,
  localparam int MW   = (NUM_MAC > 1) ? $clog2(NUM_MAC) : 1,
  localparam int IW   = MW + 1,
  localparam int TMAX = (NUM_LPM > NUM_ARP) ? ((NUM_LPM > NUM_MAC) ? NUM_LPM : NUM_MAC)
                                            : ((NUM_ARP > NUM_MAC) ? NUM_ARP : NUM_MAC),
  localparam int TW   = (TMAX > 1) ? $clog2(TMAX) : 1
)(
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrEn,
  input  logic [1:0]     wrSel,
  input  logic [TW-1:0]  wrIdx,
  input  logic [31:0]    wrKey,
  input  logic [31:0]    wrMask,
  input  logic [31:0]    wrNextHop,
  input  logic [47:0]    wrMac,
  input  logic [MW-1:0]  wrPort,
  input  logic [IW-1:0]  inSrcPort,
  input  logic [47:0]    inDstMac,
  input  logic [47:0]    inSrcMac,
  input  logic [159:0]   inIpHdr,
  input  olkStrobeT      strobe,
  output logic           macOk,
  output logic           csumOk,
  output logic           ttlOk,
  output logic           routeHit,
  output logic           arpHit,
  output logic           outValid,
  output logic [7:0]     outModCtrl,
  output logic [63:0]    outModHdr,
  output logic [IW-1:0]  outPortIdx,
  output logic           outExcept,
  output logic [47:0]    outDstMac,
  output logic [47:0]    outSrcMac,
  output logic [159:0]   outIpHdr
);
  localparam int LW = (NUM_LPM > 1) ? $clog2(NUM_LPM) : 1;
  localparam int AW = (NUM_ARP > 1) ? $clog2(NUM_ARP) : 1;

  logic [31:0]   lpmKey  [NUM_LPM];
  logic [31:0]   lpmMask [NUM_LPM];
  logic [31:0]   lpmHop  [NUM_LPM];
  logic [MW-1:0] lpmPort [NUM_LPM];
  logic [NUM_LPM-1:0] lpmVld;
  logic [31:0]   arpIp   [NUM_ARP];
  logic [47:0]   arpMac  [NUM_ARP];
  logic [NUM_ARP-1:0] arpVld;
  logic [47:0]   portMac [NUM_MAC];

  // table loading
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lpmVld <= '0;
      arpVld <= '0;
      for (int i = 0; i < NUM_LPM; i++) begin
        lpmKey[i] <= '0; lpmMask[i] <= '0; lpmHop[i] <= '0; lpmPort[i] <= '0;
      end
      for (int i = 0; i < NUM_ARP; i++) begin
        arpIp[i] <= '0; arpMac[i] <= '0;
      end
      for (int i = 0; i < NUM_MAC; i++) portMac[i] <= '0;
    end else if (wrEn) begin
      case (wrSel)
        SEL_ROUTE: if (int'(wrIdx) < NUM_LPM) begin
          lpmKey[wrIdx[LW-1:0]]  <= wrKey & wrMask;
          lpmMask[wrIdx[LW-1:0]] <= wrMask;
          lpmHop[wrIdx[LW-1:0]]  <= wrNextHop;
          lpmPort[wrIdx[LW-1:0]] <= wrPort;
          lpmVld[wrIdx[LW-1:0]]  <= 1'b1;
        end
        SEL_ARP: if (int'(wrIdx) < NUM_ARP) begin
          arpIp[wrIdx[AW-1:0]]  <= wrKey;
          arpMac[wrIdx[AW-1:0]] <= wrMac;
          arpVld[wrIdx[AW-1:0]] <= 1'b1;
        end
        SEL_PMAC: if (int'(wrIdx) < NUM_MAC) portMac[wrIdx[MW-1:0]] <= wrMac;
        default: ;
      endcase
    end
  end

  logic [MW-1:0] inK;
  logic [7:0]    ttl;
  logic [31:0]   dstIp;
  logic [19:0]   acc;
  logic [16:0]   fold1;
  logic [15:0]   fold2;
  logic [LW-1:0] best;
  logic [5:0]    bestLen;
  logic [31:0]   hopIp;
  logic [MW-1:0] egress;
  logic [AW-1:0] arpSel;
  logic [15:0]   nOldCs, nOldW, newW, newCs;
  logic [17:0]   inc;
  logic [16:0]   incF1;
  logic [15:0]   incF2;
  logic [159:0]  fwdHdr;

  // header checks and lookups
  always_comb begin
    inK   = inSrcPort[IW-1:1];
    ttl   = inIpHdr[95:88];
    dstIp = inIpHdr[31:0];
    macOk = (inDstMac == portMac[inK]);
    ttlOk = (ttl > 8'd1);

    acc = '0;
    for (int w = 0; w < 10; w++) acc = acc + 20'(inIpHdr[159-16*w -: 16]);
    fold1  = 17'(acc[15:0]) + 17'(acc[19:16]);
    fold2  = fold1[15:0] + 16'(fold1[16]);
    csumOk = (fold2 == 16'hFFFF);

    routeHit = 1'b0; bestLen = '0; best = '0;
    for (int i = 0; i < NUM_LPM; i++) begin
      if (lpmVld[i] && ((dstIp & lpmMask[i]) == lpmKey[i]) &&
          (!routeHit || 6'($countones(lpmMask[i])) > bestLen)) begin
        routeHit = 1'b1;
        bestLen  = 6'($countones(lpmMask[i]));
        best     = LW'(i);
      end
    end
    hopIp  = lpmHop[best];
    egress = lpmPort[best];

    arpHit = 1'b0; arpSel = '0;
    for (int i = 0; i < NUM_ARP; i++) begin
      if (!arpHit && arpVld[i] && arpIp[i] == hopIp) begin
        arpHit = 1'b1;
        arpSel = AW'(i);
      end
    end

    // incremental checksum: HC' = ~(~HC + ~m + m')
    nOldCs = ~inIpHdr[79:64];
    nOldW  = ~inIpHdr[95:80];
    newW   = {ttl - 8'd1, inIpHdr[87:80]};
    inc    = 18'(nOldCs) + 18'(nOldW) + 18'(newW);
    incF1  = 17'(inc[15:0]) + 17'(inc[17:16]);
    incF2  = incF1[15:0] + 16'(incF1[16]);
    newCs  = ~incF2;

    fwdHdr         = inIpHdr;
    fwdHdr[95:88]  = ttl - 8'd1;
    fwdHdr[79:64]  = newCs;
  end

  // result register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0; outModCtrl <= '0; outModHdr <= '0; outPortIdx <= '0;
      outExcept <= 1'b0; outDstMac <= '0; outSrcMac <= '0; outIpHdr <= '0;
    end else begin
      outValid   <= strobe.load;
      outModCtrl <= strobe.load ? MOD_CTRL : 8'h00;
      outExcept  <= strobe.toCpu;
      if (strobe.load) begin
        if (strobe.fwd) begin
          outPortIdx <= {egress, 1'b0};
          outModHdr  <= 64'({egress, 1'b0});
          outDstMac  <= arpMac[arpSel];
          outSrcMac  <= portMac[egress];
          outIpHdr   <= fwdHdr;
        end else begin
          outPortIdx <= {inK, strobe.toCpu};
          outModHdr  <= 64'({inK, strobe.toCpu});
          outDstMac  <= inDstMac;
          outSrcMac  <= inSrcMac;
          outIpHdr   <= inIpHdr;
        end
      end
    end
  end
endmodule

// File: rtl/olkLookup.sv
module olkLookup
  import olkPkg::*;
#(
  parameter int NUM_MAC = 4,
  parameter int NUM_LPM = 4,
  parameter int NUM_ARP = 4,
  localparam int MW   = (NUM_MAC > 1) ? $clog2(NUM_MAC) : 1,
  localparam int IW   = MW + 1,
  localparam int TMAX = (NUM_LPM > NUM_ARP) ? ((NUM_LPM > NUM_MAC) ? NUM_LPM : NUM_MAC)
                                            : ((NUM_ARP > NUM_MAC) ? NUM_ARP : NUM_MAC),
  localparam int TW   = (TMAX > 1) ? $clog2(TMAX) : 1
)(
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrEn,
  input  logic [1:0]     wrSel,
  input  logic [TW-1:0]  wrIdx,
  input  logic [31:0]    wrKey,
  input  logic [31:0]    wrMask,
  input  logic [31:0]    wrNextHop,
  input  logic [47:0]    wrMac,
  input  logic [MW-1:0]  wrPort,
  input  logic           inValid,
  input  logic [IW-1:0]  inSrcPort,
  input  logic [47:0]    inDstMac,
  input  logic [47:0]    inSrcMac,
  input  logic [159:0]   inIpHdr,
  output logic           outValid,
  output logic [7:0]     outModCtrl,
  output logic [63:0]    outModHdr,
  output logic [IW-1:0]  outPortIdx,
  output logic           outExcept,
  output logic [47:0]    outDstMac,
  output logic [47:0]    outSrcMac,
  output logic [159:0]   outIpHdr
);
  olkStrobeT strobe;
  logic macOk, csumOk, ttlOk, routeHit, arpHit;

  olkCtrl ctrlI (
    .inValid(inValid), .isCpuSrc(inSrcPort[0]), .macOk(macOk), .csumOk(csumOk),
    .ttlOk(ttlOk), .routeHit(routeHit), .arpHit(arpHit), .strobe(strobe)
  );

  olkData #(.NUM_MAC(NUM_MAC), .NUM_LPM(NUM_LPM), .NUM_ARP(NUM_ARP)) dataI (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrIdx(wrIdx), .wrKey(wrKey),
    .wrMask(wrMask), .wrNextHop(wrNextHop), .wrMac(wrMac), .wrPort(wrPort),
    .inSrcPort(inSrcPort), .inDstMac(inDstMac), .inSrcMac(inSrcMac), .inIpHdr(inIpHdr),
    .strobe(strobe), .macOk(macOk), .csumOk(csumOk), .ttlOk(ttlOk),
    .routeHit(routeHit), .arpHit(arpHit), .outValid(outValid), .outModCtrl(outModCtrl),
    .outModHdr(outModHdr), .outPortIdx(outPortIdx), .outExcept(outExcept),
    .outDstMac(outDstMac), .outSrcMac(outSrcMac), .outIpHdr(outIpHdr)
  );
endmodule

// File: rtl/olkLookupChk.sv
module olkLookupChk #(
  parameter int IW = 3
)(
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic [IW-1:0] inSrcPort,
  input logic [47:0]   inDstMac,
  input logic [159:0]  inIpHdr,
  input logic          outValid,
  input logic [7:0]    outModCtrl,
  input logic [63:0]   outModHdr,
  input logic [IW-1:0] outPortIdx,
  input logic          outExcept,
  input logic [47:0]   outDstMac,
  input logic [159:0]  outIpHdr
);
  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rstN) inValid |=> outValid);
  // R1
  idle_chk: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> !outValid);
  // R2
  mod_hdr_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outModCtrl == 8'h04 && outModHdr == 64'(outPortIdx)));
  // R3
  cpu_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSrcPort[0]) |=>
      (!outExcept && outPortIdx == {$past(inSrcPort[IW-1:1]), 1'b0} && outIpHdr == $past(inIpHdr)));
  // R4
  ttl_exc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inSrcPort[0] && inIpHdr[95:89] == 7'd0) |=>
      (outExcept && outPortIdx == {$past(inSrcPort[IW-1:1]), 1'b1}));
  // R6
  exc_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outExcept) |-> (outIpHdr == $past(inIpHdr) && outDstMac == $past(inDstMac)));
  // R9
  ttl_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inSrcPort[0]) |=> (outExcept || outIpHdr[95:88] == $past(inIpHdr[95:88]) - 8'd1));
endmodule

bind olkLookup olkLookupChk #(.IW(IW)) chkI (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inSrcPort(inSrcPort), .inDstMac(inDstMac),
  .inIpHdr(inIpHdr), .outValid(outValid), .outModCtrl(outModCtrl), .outModHdr(outModHdr),
  .outPortIdx(outPortIdx), .outExcept(outExcept), .outDstMac(outDstMac), .outIpHdr(outIpHdr)
);

// File: tb/tb_olkLookup.sv
module tb_olkLookup;
  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 0; logic [1:0] wrSel = 0; logic [1:0] wrIdx = 0;
  logic [31:0] wrKey = 0, wrMask = 0, wrNextHop = 0; logic [47:0] wrMac = 0; logic [1:0] wrPort = 0;
  logic inValid = 0; logic [2:0] inSrcPort = 0; logic [47:0] inDstMac = 0, inSrcMac = 0;
  logic [159:0] inIpHdr = 0;
  logic outValid, outExcept; logic [7:0] outModCtrl; logic [63:0] outModHdr;
  logic [2:0] outPortIdx; logic [47:0] outDstMac, outSrcMac; logic [159:0] outIpHdr;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  olkLookup dut (.*);

  // bench copy of table contents
  logic [47:0] bPortMac [4];
  logic [31:0] bKey [4], bMask [4], bHop [4]; logic [1:0] bPort [4]; logic [3:0] bRVld = 0;
  logic [31:0] bArpIp [4]; logic [47:0] bArpMac [4]; logic [3:0] bAVld = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] onesSum(input logic [159:0] h);
    logic [19:0] a = 0; logic [16:0] f;
    for (int w = 0; w < 10; w++) a += 20'(h[159-16*w -: 16]);
    f = 17'(a[15:0]) + 17'(a[19:16]);
    return f[15:0] + 16'(f[16]);
  endfunction

  function automatic logic [159:0] mkHdr(input logic [7:0] ttl, input logic [31:0] src,
                                         input logic [31:0] dst, input logic [15:0] id);
    logic [159:0] h = {16'h4500, 16'h0054, id, 16'h4000, ttl, 8'h11, 16'h0000, src, dst};
    h[79:64] = ~onesSum(h);
    return h;
  endfunction

  task automatic wrTbl(input logic [1:0] sel, input int idx, input logic [31:0] key,
                       input logic [31:0] mask, input logic [31:0] hop,
                       input logic [47:0] mac, input logic [1:0] port);
    @(negedge clk);
    wrEn = 1; wrSel = sel; wrIdx = 2'(idx); wrKey = key; wrMask = mask;
    wrNextHop = hop; wrMac = mac; wrPort = port;
    @(negedge clk); wrEn = 0;
    case (sel)
      2'd0: begin bKey[idx] = key & mask; bMask[idx] = mask; bHop[idx] = hop; bPort[idx] = port; bRVld[idx] = 1; end
      2'd1: begin bArpIp[idx] = key; bArpMac[idx] = mac; bAVld[idx] = 1; end
      default: bPortMac[idx] = mac;
    endcase
  endtask

  // expected result from the requirements; returns a tag for the deciding rule
  task automatic model(input logic [2:0] src, input logic [47:0] dm, input logic [47:0] sm,
                       input logic [159:0] h, output bit exc, output logic [2:0] idx,
                       output logic [47:0] eD, output logic [47:0] eS, output logic [159:0] eH,
                       output string tag);
    logic [1:0] k = src[2:1]; bit hit = 0; int bl = -1; int bi = 0; bit ah = 0; int ai = 0;
    exc = 0; idx = src; eD = dm; eS = sm; eH = h; tag = "R9";
    if (src[0]) begin idx = {k, 1'b0}; tag = "R3"; return; end
    for (int i = 0; i < 4; i++)
      if (bRVld[i] && (h[31:0] & bMask[i]) == bKey[i] && $countones(bMask[i]) > bl) begin
        hit = 1; bl = $countones(bMask[i]); bi = i;
      end
    if (hit) for (int i = 0; i < 4; i++)
      if (!ah && bAVld[i] && bArpIp[i] == bHop[bi]) begin ah = 1; ai = i; end
    if (h[95:88] < 8'd2) tag = "R4";
    else if (dm != bPortMac[k]) tag = "R5";
    else if (onesSum(h) != 16'hFFFF) tag = "R6";
    else if (!hit) tag = "R7";
    else if (!ah) tag = "R8";
    if (tag != "R9") begin exc = 1; idx = {k, 1'b1}; return; end
    idx = {bPort[bi], 1'b0}; eD = bArpMac[ai]; eS = bPortMac[bPort[bi]];
    eH = h; eH[95:88] = h[95:88] - 8'd1;
  endtask

  task automatic sendPkt(input logic [2:0] src, input logic [47:0] dm, input logic [47:0] sm,
                         input logic [159:0] h, input bit withWr, input string force_tag);
    bit exc; logic [2:0] idx; logic [47:0] eD, eS; logic [159:0] eH; string tag;
    logic [159:0] maskCs = ~(160'hFFFF << 64);
    model(src, dm, sm, h, exc, idx, eD, eS, eH, tag);
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    inValid = 1; inSrcPort = src; inDstMac = dm; inSrcMac = sm; inIpHdr = h;
    if (withWr) wrEn = 1;
    @(negedge clk);
    inValid = 0; wrEn = 0;
    chk(outValid === 1'b1, "R1", "outValid", 160'(outValid), 1);
    chk(outModCtrl === 8'h04 && outModHdr === 64'(idx), "R2", "modHdr",
        160'(outModHdr), 160'(idx));
    chk(outPortIdx === idx, tag, "portIdx", 160'(outPortIdx), 160'(idx));
    chk(outExcept === exc, tag, "except", 160'(outExcept), 160'(exc));
    chk(outDstMac === eD, tag, "dstMac", 160'(outDstMac), 160'(eD));
    chk(outSrcMac === eS, tag, "srcMac", 160'(outSrcMac), 160'(eS));
    if (!exc && !src[0]) begin
      chk((outIpHdr & maskCs) === (eH & maskCs), "R9", "hdrFields", outIpHdr, eH);
      chk(onesSum(outIpHdr) === 16'hFFFF, "R9", "csumSum", 160'(onesSum(outIpHdr)), 160'hFFFF);
    end else
      chk(outIpHdr === eH, tag, "hdrUnchanged", outIpHdr, eH);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] dsts [6];
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(outValid === 1'b0 && outModCtrl === 8'h00, "R1", "resetState", 160'(outValid), 0);
    rstN = 1;
    @(negedge clk);
    chk(outValid === 1'b0, "R1", "idleAfterReset", 160'(outValid), 0);
    // R7 empty tables after reset: route miss
    for (int p = 0; p < 4; p++) bPortMac[p] = 48'h0;
    sendPkt(3'd0, 48'h0, 48'h1, mkHdr(8'd64, 32'h0a000001, 32'h0a010203, 16'h1), 0, "R10");

    for (int p = 0; p < 4; p++) wrTbl(2'd2, p, 0, 0, 0, 48'h02_00_00_00_00_10 + 48'(p), 0);
    wrTbl(2'd0, 0, 32'h0a000000, 32'hff000000, 32'h0a000001, 0, 2'd1);
    wrTbl(2'd0, 1, 32'h0a010000, 32'hffff0000, 32'h0a010001, 0, 2'd2);
    wrTbl(2'd0, 2, 32'h0a010200, 32'hffffff00, 32'h0a010201, 0, 2'd3);
    wrTbl(2'd0, 3, 32'hac100000, 32'hfff00000, 32'hac100001, 0, 2'd0);
    wrTbl(2'd1, 0, 32'h0a000001, 0, 0, 48'h0a_aa_00_00_00_01, 0);
    wrTbl(2'd1, 1, 32'h0a010001, 0, 0, 48'h0a_aa_00_00_00_02, 0);
    wrTbl(2'd1, 2, 32'h0a010201, 0, 0, 48'h0a_aa_00_00_00_03, 0);

    // directed: longest prefix (/24 beats /16 and /8), R7
    sendPkt(3'd2, bPortMac[1], 48'h5, mkHdr(8'd64, 32'hc0a80001, 32'h0a010277, 16'h2), 0, "R7");
    // /16 wins over /8
    sendPkt(3'd4, bPortMac[2], 48'h5, mkHdr(8'd9, 32'hc0a80001, 32'h0a01ff00, 16'h3), 0, "R7");
    // R4 TTL 1 and TTL 0; TTL 2 forwards
    sendPkt(3'd6, bPortMac[3], 48'h5, mkHdr(8'd1, 32'hc0a80001, 32'h0a010277, 16'h4), 0, "R4");
    sendPkt(3'd0, bPortMac[0], 48'h5, mkHdr(8'd0, 32'hc0a80001, 32'h0a010277, 16'h5), 0, "R4");
    sendPkt(3'd0, bPortMac[0], 48'h5, mkHdr(8'd2, 32'hc0a80001, 32'h0a010277, 16'h6), 0, "R9");
    // R3 from CPU queue 1 -> MAC index 0, with a TTL that would otherwise divert
    sendPkt(3'd1, 48'h123, 48'h456, mkHdr(8'd0, 32'h1, 32'h2, 16'h7), 0, "R3");
    // R5 mismatch, R6 bad checksum
    sendPkt(3'd2, bPortMac[0], 48'h5, mkHdr(8'd64, 32'h1, 32'h0a010277, 16'h8), 0, "R5");
    begin
      logic [159:0] bad = mkHdr(8'd64, 32'h1, 32'h0a010277, 16'h9);
      bad[79:64] ^= 16'h0101;
      sendPkt(3'd2, bPortMac[1], 48'h5, bad, 0, "R6");
    end
    // R8 ARP miss via 172.16/12 route; then same-cycle write (R10)
    sendPkt(3'd4, bPortMac[2], 48'h5, mkHdr(8'd64, 32'h1, 32'hac10beef, 16'ha), 0, "R8");
    wrSel = 2'd1; wrIdx = 2'd3; wrKey = 32'hac100001; wrMac = 48'h0a_aa_00_00_00_04;
    sendPkt(3'd4, bPortMac[2], 48'h5, mkHdr(8'd64, 32'h1, 32'hac10beef, 16'hb), 1, "R10");
    bArpIp[3] = 32'hac100001; bArpMac[3] = 48'h0a_aa_00_00_00_04; bAVld[3] = 1;
    sendPkt(3'd4, bPortMac[2], 48'h5, mkHdr(8'd64, 32'h1, 32'hac10beef, 16'hc), 0, "R10");

    // random traffic
    dsts = '{32'h0a010205, 32'h0a01aa05, 32'h0a7f0001, 32'hac1f0003, 32'hc0a80304, 32'h08080808};
    for (int n = 0; n < 400; n++) begin
      logic [2:0] src = 3'($urandom % 8);
      logic [7:0] ttl;
      logic [47:0] dm;
      logic [159:0] h;
      int r = int'($urandom % 8);
      ttl = (r == 0) ? 8'd0 : (r == 1) ? 8'd1 : 8'(2 + $urandom % 254);
      dm = ($urandom % 8 == 0) ? 48'(64'($urandom)) : bPortMac[src[2:1]];
      h = mkHdr(ttl, $urandom, dsts[$urandom % 6], 16'($urandom));
      if ($urandom % 10 == 0) h[79:64] ^= 16'h0010;
      sendPkt(src, dm, 48'(64'($urandom)), h, 0, "");
    end

    @(negedge clk);
    chk(outValid === 1'b0, "R1", "idleAfterTraffic", 160'(outValid), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule